// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block walks an LPDDR2 SDRAM through its power-up initialization after a single start pulse. It emits a fixed series of commands (no-operation, dummy write, mode-register writes, normal mode) on a simple command port. The port carries a command type, an 8-bit mode-register address and a valid flag. Each command is held until the downstream controller returns a one-cycle acknowledge.

Between commands the block inserts pauses whose lengths, in clock cycles, arrive on input ports. It also drives the side controls the sequence needs: the ZQ calibration type field and the input-buffer enable. At the end it loads a refresh count and a temperature-polling configuration into output registers. It reports busy while running and a one-cycle done pulse at the end. The contents of the mode registers, the PHY and the calibration circuits lie outside the block.

Top module: `lpddr2_init_seq`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, cmd_valid_o, ibuf_open_o, refresh_load_o and mr4_load_o are 0, and zq_type_o is 00.
- R2: A start_i pulse while idle sets busy_o from the next cycle on. A start_i pulse while busy_o is 1 (including the cycle of the final load) has no effect: no command appears and busy_o stays 0 after done.
- R3: cmd_valid_o, cmd_type_o and cmd_addr_o stay unchanged until cmd_ack_i is seen. The next command is not presented before the current one has been acknowledged.
- R4: The command types are encoded as 0 NOP, 1 mode-register write, 2 normal mode and 3 dummy write. Commands appear in this exact order:
  - NOP, then dummy write, then NOP.
  - Mode-register writes to 63 and then 10.
  - Mode-register writes to 1, 2, 3 and 16.
  - NOP.
  - Mode-register writes to 5, 6, 8 and 0.
  - Normal mode.
- R5: Three pauses apply:
  - The second NOP appears no sooner than pause_short_i cycles after the dummy write is acknowledged.
  - The write to register 63 appears no sooner than pause_long_i cycles after the second NOP is acknowledged.
  - The write to register 10 appears no sooner than pause_init5_i cycles after the write to 63 is acknowledged.
- R6: zq_type_o uses 00 none, 01 reset, 10 short, 11 long. It reads 01 while the write to register 10 is presented and 10 from the write to register 1 onward. It holds its value until the block changes it, including across the idle time into the next run, and never shows 11.
- R7: ibuf_open_o is 1 exactly while the third NOP, the writes to 5, 6, 8 and 0, and the normal-mode command are presented. It is 0 while every earlier command is presented, and it is 0 again before the refresh load.
- R8: After normal mode is acknowledged, refresh_load_o pulses for one cycle with refresh_cnt_o equal to refresh_val_i. In the next cycle mr4_load_o pulses with mr4_cfg_o equal to mr4_cfg_i.
- R9: done_o is a one-cycle pulse in the same cycle as mr4_load_o, and busy_o is 0 in that cycle.
- R10: A start_i pulse after done_o runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| pause_short_i | input | CNT_W | Cycles after the dummy write |
| pause_long_i | input | CNT_W | Cycles before the device reset |
| pause_init5_i | input | CNT_W | Cycles after the device reset |
| refresh_val_i | input | REF_W | Refresh count to load |
| mr4_cfg_i | input | MR4_W | Temperature-polling setting to load |
| cmd_ack_i | input | 1 | One-cycle command acknowledge |
| cmd_valid_o | output | 1 | Command presented |
| cmd_type_o | output | 2 | Command type |
| cmd_addr_o | output | 8 | Mode-register address |
| zq_type_o | output | 2 | ZQ calibration type |
| ibuf_open_o | output | 1 | Input buffers open |
| refresh_cnt_o | output | REF_W | Loaded refresh count |
| refresh_load_o | output | 1 | Refresh load strobe |
| mr4_cfg_o | output | MR4_W | Loaded temperature-polling setting |
| mr4_load_o | output | 1 | Temperature-polling load strobe |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished pulse |

## Verification
The collision of interest is a start pulse that lands on the same clock edge as the final temperature-polling load and done pulse. At that edge the sequencer is still busy, so the pulse must be dropped. The bench raises start_i in the cycle right after the refresh load strobe is seen. It then checks that done is a single pulse, that busy stays low and that no command is presented for several cycles. A second collision, a start pulse in the middle of a run, is judged by the scoreboard: the command trace must stay in order with no repeat of the opening NOP.

// File: rtl/lpddr2_init_pkg.sv
// Shared types for the LPDDR2 initialization sequencer.
// Assumes the step list is fixed; only pause lengths and load values vary.
package lpddr2_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP      = 2'd0,
        CMD_MRW      = 2'd1,
        CMD_NORMAL   = 2'd2,
        CMD_DUMMY_WR = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_WAIT = 2'd1,
        K_CTL  = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        A_NONE     = 3'd0,
        A_ZQ_RST   = 3'd1,
        A_ZQ_SHORT = 3'd2,
        A_IB_OPEN  = 3'd3,
        A_IB_CLOSE = 3'd4,
        A_LD_REF   = 3'd5,
        A_LD_MR4   = 3'd6
    } act_e;

    typedef enum logic [1:0] {
        W_SHORT = 2'd0,
        W_LONG  = 2'd1,
        W_INIT5 = 2'd2
    } wsel_e;

    localparam logic [1:0] ZQ_NONE  = 2'b00;
    localparam logic [1:0] ZQ_RESET = 2'b01;
    localparam logic [1:0] ZQ_SHORT = 2'b10;

    localparam int NUM_STEPS = 24;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    typedef struct packed {
        kind_e      kind;
        cmd_e       cmd;
        logic [7:0] addr;
        act_e       act;
        wsel_e      wsel;
    } step_t;

endpackage

// File: rtl/lpddr2_step_rom.sv
// Step table: decodes a step index into the action for that step.
// Assumes indices beyond the last step are never acted on (decoded as no-op).
module lpddr2_step_rom
    import lpddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o
);

    function automatic step_t mk(kind_e k, cmd_e c, logic [7:0] a, act_e x, wsel_e w);
        step_t s;
        s.kind = k; s.cmd = c; s.addr = a; s.act = x; s.wsel = w;
        return s;
    endfunction

    // Combinational decode of the fixed initialization order.
    always_comb begin
        case (idx_i)
            5'd0:    step_o = mk(K_CMD,  CMD_NOP,      8'd0,  A_NONE,     W_SHORT);
            5'd1:    step_o = mk(K_CMD,  CMD_DUMMY_WR, 8'd0,  A_NONE,     W_SHORT);
            5'd2:    step_o = mk(K_WAIT, CMD_NOP,      8'd0,  A_NONE,     W_SHORT);
            5'd3:    step_o = mk(K_CMD,  CMD_NOP,      8'd0,  A_NONE,     W_SHORT);
            5'd4:    step_o = mk(K_WAIT, CMD_NOP,      8'd0,  A_NONE,     W_LONG);
            5'd5:    step_o = mk(K_CMD,  CMD_MRW,      8'd63, A_NONE,     W_SHORT);
            5'd6:    step_o = mk(K_WAIT, CMD_NOP,      8'd0,  A_NONE,     W_INIT5);
            5'd7:    step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_ZQ_RST,   W_SHORT);
            5'd8:    step_o = mk(K_CMD,  CMD_MRW,      8'd10, A_NONE,     W_SHORT);
            5'd9:    step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_ZQ_SHORT, W_SHORT);
            5'd10:   step_o = mk(K_CMD,  CMD_MRW,      8'd1,  A_NONE,     W_SHORT);
            5'd11:   step_o = mk(K_CMD,  CMD_MRW,      8'd2,  A_NONE,     W_SHORT);
            5'd12:   step_o = mk(K_CMD,  CMD_MRW,      8'd3,  A_NONE,     W_SHORT);
            5'd13:   step_o = mk(K_CMD,  CMD_MRW,      8'd16, A_NONE,     W_SHORT);
            5'd14:   step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_IB_OPEN,  W_SHORT);
            5'd15:   step_o = mk(K_CMD,  CMD_NOP,      8'd0,  A_NONE,     W_SHORT);
            5'd16:   step_o = mk(K_CMD,  CMD_MRW,      8'd5,  A_NONE,     W_SHORT);
            5'd17:   step_o = mk(K_CMD,  CMD_MRW,      8'd6,  A_NONE,     W_SHORT);
            5'd18:   step_o = mk(K_CMD,  CMD_MRW,      8'd8,  A_NONE,     W_SHORT);
            5'd19:   step_o = mk(K_CMD,  CMD_MRW,      8'd0,  A_NONE,     W_SHORT);
            5'd20:   step_o = mk(K_CMD,  CMD_NORMAL,   8'd0,  A_NONE,     W_SHORT);
            5'd21:   step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_IB_CLOSE, W_SHORT);
            5'd22:   step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_LD_REF,   W_SHORT);
            5'd23:   step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_LD_MR4,   W_SHORT);
            default: step_o = mk(K_CTL,  CMD_NOP,      8'd0,  A_NONE,     W_SHORT);
        endcase
    end

endmodule

// File: rtl/lpddr2_pause_timer.sv
// Pause down-counter: loads a cycle count, then counts down to zero.
// Assumes load is a single-cycle request; expired_o is high while the count is zero.
module lpddr2_pause_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lpddr2_init_seq.sv
// LPDDR2 initialization sequencer top: steps through the fixed command list,
// holds each command until acknowledged, inserts the pauses, drives the ZQ type
// and input-buffer controls, and loads refresh and temperature-polling settings.
// Assumes cmd_ack_i is asserted only while cmd_valid_o is high.
module lpddr2_init_seq
    import lpddr2_init_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REF_W = 16,
    parameter int MR4_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] pause_short_i,
    input  logic [CNT_W-1:0] pause_long_i,
    input  logic [CNT_W-1:0] pause_init5_i,
    input  logic [REF_W-1:0] refresh_val_i,
    input  logic [MR4_W-1:0] mr4_cfg_i,
    input  logic             cmd_ack_i,
    output logic             cmd_valid_o,
    output logic [1:0]       cmd_type_o,
    output logic [7:0]       cmd_addr_o,
    output logic [1:0]       zq_type_o,
    output logic             ibuf_open_o,
    output logic [REF_W-1:0] refresh_cnt_o,
    output logic             refresh_load_o,
    output logic [MR4_W-1:0] mr4_cfg_o,
    output logic             mr4_load_o,
    output logic             busy_o,
    output logic             done_o
);

    logic              busy_q;
    logic              armed_q;
    logic [STEP_W-1:0] step_q;
    step_t             cur;
    logic              tmr_load;
    logic              tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic [1:0]        zq_q;
    logic              ibuf_q;

    lpddr2_step_rom u_rom (
        .idx_i  (step_q),
        .step_o (cur)
    );

    // Pick the pause length for the current wait step.
    always_comb begin
        case (cur.wsel)
            W_LONG:  tmr_val = pause_long_i;
            W_INIT5: tmr_val = pause_init5_i;
            default: tmr_val = pause_short_i;
        endcase
    end

    assign tmr_load = busy_q && (cur.kind == K_WAIT) && !armed_q;

    lpddr2_pause_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_expired)
    );

    // Step sequencing, side controls and final loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q         <= 1'b0;
            armed_q        <= 1'b0;
            step_q         <= '0;
            zq_q           <= ZQ_NONE;
            ibuf_q         <= 1'b0;
            refresh_cnt_o  <= '0;
            mr4_cfg_o      <= '0;
            refresh_load_o <= 1'b0;
            mr4_load_o     <= 1'b0;
            done_o         <= 1'b0;
        end else begin
            refresh_load_o <= 1'b0;
            mr4_load_o     <= 1'b0;
            done_o         <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    armed_q <= 1'b0;
                    step_q  <= '0;
                end
            end else begin
                case (cur.kind)
                    K_CMD: begin
                        if (cmd_ack_i) step_q <= step_q + 1'b1;
                    end
                    K_WAIT: begin
                        if (!armed_q) begin
                            armed_q <= 1'b1;
                        end else if (tmr_expired) begin
                            armed_q <= 1'b0;
                            step_q  <= step_q + 1'b1;
                        end
                    end
                    default: begin
                        step_q <= step_q + 1'b1;
                        case (cur.act)
                            A_ZQ_RST:   zq_q   <= ZQ_RESET;
                            A_ZQ_SHORT: zq_q   <= ZQ_SHORT;
                            A_IB_OPEN:  ibuf_q <= 1'b1;
                            A_IB_CLOSE: ibuf_q <= 1'b0;
                            A_LD_REF: begin
                                refresh_cnt_o  <= refresh_val_i;
                                refresh_load_o <= 1'b1;
                            end
                            A_LD_MR4: begin
                                mr4_cfg_o  <= mr4_cfg_i;
                                mr4_load_o <= 1'b1;
                                done_o     <= 1'b1;
                                busy_q     <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    assign cmd_valid_o = busy_q && (cur.kind == K_CMD);
    assign cmd_type_o  = cmd_valid_o ? cur.cmd  : CMD_NOP;
    assign cmd_addr_o  = cmd_valid_o ? cur.addr : 8'd0;
    assign zq_type_o   = zq_q;
    assign ibuf_open_o = ibuf_q;
    assign busy_o      = busy_q;

endmodule

// File: rtl/lpddr2_init_seq_chk.sv
// Property checker for the initialization sequencer, bound to every instance.
// Assumes the synchronous active-low reset of the design it watches.
module lpddr2_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cmd_ack_i,
    input logic       cmd_valid_o,
    input logic [1:0] cmd_type_o,
    input logic [7:0] cmd_addr_o,
    input logic [1:0] zq_type_o,
    input logic       ibuf_open_o,
    input logic       refresh_load_o,
    input logic       mr4_load_o,
    input logic       busy_o,
    input logic       done_o
);

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ack_i) |=> (cmd_valid_o && $stable(cmd_type_o) && $stable(cmd_addr_o)));

    // R3
    cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o);

    // R6
    zq_no_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zq_type_o != 2'b11);

    // R7
    ibuf_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ibuf_open_o |-> busy_o);

    // R8
    mr4_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_load_o |=> (mr4_load_o && !ibuf_open_o));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mr4_load_o && !busy_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind lpddr2_init_seq lpddr2_init_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .cmd_ack_i      (cmd_ack_i),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_type_o     (cmd_type_o),
    .cmd_addr_o     (cmd_addr_o),
    .zq_type_o      (zq_type_o),
    .ibuf_open_o    (ibuf_open_o),
    .refresh_load_o (refresh_load_o),
    .mr4_load_o     (mr4_load_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
);

// File: tb/lpddr2_init_seq_tb.sv
// Scoreboard bench: the driver pushes the expected command trace, the responder
// acknowledges with varying latency and compares each command as it appears.
module lpddr2_init_seq_tb;

    localparam int CNT_W = 16;
    localparam int REF_W = 16;
    localparam int MR4_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] pause_short_i = '0;
    logic [CNT_W-1:0] pause_long_i = '0;
    logic [CNT_W-1:0] pause_init5_i = '0;
    logic [REF_W-1:0] refresh_val_i = '0;
    logic [MR4_W-1:0] mr4_cfg_i = '0;
    logic             cmd_ack_i = 1'b0;
    logic             cmd_valid_o;
    logic [1:0]       cmd_type_o;
    logic [7:0]       cmd_addr_o;
    logic [1:0]       zq_type_o;
    logic             ibuf_open_o;
    logic [REF_W-1:0] refresh_cnt_o;
    logic             refresh_load_o;
    logic [MR4_W-1:0] mr4_cfg_o;
    logic             mr4_load_o;
    logic             busy_o;
    logic             done_o;

    int errors = 0;
    int checks = 0;
    logic [12:0] exp_q[$];
    int          gap_q[$];

    always #4 clk = ~clk;

    lpddr2_init_seq #(.CNT_W(CNT_W), .REF_W(REF_W), .MR4_W(MR4_W)) u_dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Expected item: {type, addr, zq, ibuf} plus minimum idle cycles before it.
    task automatic push_cmd(input logic [1:0] t, input logic [7:0] a,
                            input logic [1:0] zq, input logic ib, input int gap);
        exp_q.push_back({t, a, zq, ib});
        gap_q.push_back(gap);
    endtask

    task automatic push_run(input logic [1:0] zq0);
        push_cmd(2'd0, 8'd0,  zq0,   1'b0, 0);
        push_cmd(2'd3, 8'd0,  zq0,   1'b0, 0);
        push_cmd(2'd0, 8'd0,  zq0,   1'b0, int'(pause_short_i));
        push_cmd(2'd1, 8'd63, zq0,   1'b0, int'(pause_long_i));
        push_cmd(2'd1, 8'd10, 2'b01, 1'b0, int'(pause_init5_i));
        push_cmd(2'd1, 8'd1,  2'b10, 1'b0, 0);
        push_cmd(2'd1, 8'd2,  2'b10, 1'b0, 0);
        push_cmd(2'd1, 8'd3,  2'b10, 1'b0, 0);
        push_cmd(2'd1, 8'd16, 2'b10, 1'b0, 0);
        push_cmd(2'd0, 8'd0,  2'b10, 1'b1, 0);
        push_cmd(2'd1, 8'd5,  2'b10, 1'b1, 0);
        push_cmd(2'd1, 8'd6,  2'b10, 1'b1, 0);
        push_cmd(2'd1, 8'd8,  2'b10, 1'b1, 0);
        push_cmd(2'd1, 8'd0,  2'b10, 1'b1, 0);
        push_cmd(2'd2, 8'd0,  2'b10, 1'b1, 0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // Responder and monitor: compares each new command, acknowledges after a latency.
    initial begin
        int gap = 0;
        int wt = 0;
        int lat = 0;
        bit fresh = 1'b1;
        logic [12:0] e;
        int g;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cmd_ack_i = 1'b0; gap = 0; fresh = 1'b1;
            end else if (cmd_ack_i) begin
                cmd_ack_i = 1'b0;
                if (!cmd_valid_o) gap++;
            end else if (cmd_valid_o) begin
                if (fresh) begin
                    fresh = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected command", cmd_type_o, 0);
                    end else begin
                        e = exp_q.pop_front();
                        g = gap_q.pop_front();
                        // R4 order, R6 ZQ type, R7 buffers, R5 pause
                        check({cmd_type_o, cmd_addr_o} == e[12:3], "R4 command",
                              {cmd_type_o, cmd_addr_o}, e[12:3]);
                        check(zq_type_o == e[2:1], "R6 zq type", zq_type_o, e[2:1]);
                        check(ibuf_open_o == e[0], "R7 input buffers", ibuf_open_o, e[0]);
                        check(gap >= g, "R5 pause", gap, g);
                    end
                end
                if (wt >= lat) begin
                    cmd_ack_i = 1'b1; wt = 0; lat = (lat + 1) % 3;
                    fresh = 1'b1; gap = 0;
                end else begin
                    wt++;
                end
            end else begin
                gap++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    endtask

    task automatic finish_checks(input bit collide);
        do @(negedge clk); while (!refresh_load_o);
        check(refresh_cnt_o == refresh_val_i, "R8 refresh count", refresh_cnt_o, refresh_val_i);
        check(exp_q.size() == 0, "R4 all commands seen", exp_q.size(), 0);
        check(ibuf_open_o == 1'b0, "R7 buffers closed", ibuf_open_o, 0);
        if (collide) start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(mr4_load_o == 1'b1, "R8 mr4 load", mr4_load_o, 1);
        check(mr4_cfg_o == mr4_cfg_i, "R8 mr4 value", mr4_cfg_o, mr4_cfg_i);
        check(done_o == 1'b1, "R9 done", done_o, 1);
        check(busy_o == 1'b0, "R9 idle at done", busy_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    endtask

    // Driver: runs the sequence twice with distinct pauses and collisions.
    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !cmd_valid_o, "R1 idle after reset", busy_o, 0);
        check(zq_type_o == 2'b00, "R1 zq none", zq_type_o, 0);
        check(!ibuf_open_o && !refresh_load_o && !mr4_load_o, "R1 controls low", ibuf_open_o, 0);
        rst_n = 1'b1;
        pause_short_i = 16'd3; pause_long_i = 16'd20; pause_init5_i = 16'd5;
        refresh_val_i = 16'h1234; mr4_cfg_i = 16'hA5C3;
        push_run(2'b00);
        pulse_start();
        repeat (10) @(negedge clk);
        start_i = 1'b1;                      // R2 start while busy ignored
        @(negedge clk); start_i = 1'b0;
        finish_checks(1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!busy_o && !cmd_valid_o, "R2 start at done ignored", busy_o, 0);
        end
        check(zq_type_o == 2'b10, "R6 zq held while idle", zq_type_o, 2);
        // R10 second run, zero-length pauses
        pause_short_i = 16'd0; pause_long_i = 16'd0; pause_init5_i = 16'd0;
        refresh_val_i = 16'h00FF; mr4_cfg_i = 16'h0042;
        push_run(2'b10);
        pulse_start();
        finish_checks(1'b0);
        check(exp_q.size() == 0, "R10 rerun complete", exp_q.size(), 0);
        finish_run();
    end

endmodule